// File: doc/BRIEF.md
# ADC Result Word Formatter

This block takes the result of a finished analog-to-digital conversion and packs it into a 16-bit data word for a host. The sample arrives as a 15-bit two's-complement value: one sign bit plus fourteen bits weighted 2^13 down to 2^0. An out-of-range flag and a two-bit resolution select arrive with it. The block keeps 14, 11 or 8 significant bits. When it keeps fewer than 14, it replaces the dropped low bits with a half-adjust pattern: a single 1 directly below the last retained bit, followed by zeros. It then appends the overload flag and holds the word for the host.

Word positions are counted from the most significant end. Position 0 is vector bit 15, and position k is vector bit 15-k. The binary point stays in the same place for every resolution, so a host can scale the word the same way whatever the format. A done pulse captures the new word and raises a valid flag. A read pulse from the host drops the flag. If a new done pulse arrives before the read, it replaces the held word.

Top module: `adc_word_fmt`

## Requirements
- R1: `word_o[15]` (position 0) carries the sign bit `sample_i[14]` (0 positive, 1 negative). `word_o[14:1]` (positions 1..14) carry the retained magnitude-weight bits, from 2^13 down to 2^0. Negative values stay in two's-complement form.
- R2: With `fmt_i` = 2'b00 (14-bit), the captured word is `{sample_i[14:0], ovr_i}`, with no bits altered.
- R3: With `fmt_i` = 2'b01 (11-bit), `word_o[15:4]` equals `sample_i[14:3]` and `word_o[3:1]` equals 3'b100 (position 12 is 1, positions 13 and 14 are 0).
- R4: With `fmt_i` = 2'b10 (8-bit), `word_o[15:7]` equals `sample_i[14:6]` and `word_o[6:1]` equals 6'b100000 (position 9 is 1, positions 10 to 14 are 0).
- R5: `fmt_i` = 2'b11 is formatted exactly as the 14-bit format.
- R6: `word_o[0]` (position 15) equals `ovr_i` as sampled with the done pulse. The remaining bits are still formatted by R1 to R4.
- R7: On a clock edge with `done_i` high, the formatted word is registered, and from the next cycle `valid_o` is 1.
- R8: On an edge with `rd_i` high and `done_i` low, `valid_o` goes to 0 and `word_o` keeps its value.
- R9: When `done_i` and `rd_i` are high on the same edge, the new word is captured and `valid_o` stays 1.
- R10: On edges without `done_i`, `word_o` does not change, whatever the sample, flag or format inputs do.
- R11: While `rst_n` is low, `word_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Conversion finished; capture this cycle |
| sample_i | input | 15 | Two's-complement sample, sign in bit 14 |
| ovr_i | input | 1 | Input was out of range |
| fmt_i | input | 2 | Resolution: 00 = 14-bit, 01 = 11-bit, 10 = 8-bit, 11 = 14-bit |
| rd_i | input | 1 | Host read strobe; clears valid |
| word_o | output | 16 | Held formatted data word |
| valid_o | output | 1 | A word is waiting for the host |

## Verification
The assertions assume that `sample_i`, `ovr_i` and `fmt_i` are settled on every edge where `done_i` is high. They also assume that `rd_i` and `done_i` are single-cycle, synchronous pulses. The bench changes every input on the falling edge and holds it through the following rising edge, so each capture sees stable values. The bench also deliberately changes the sample, flag and format inputs on cycles without `done_i`. This shows that the held word ignores them, without ever breaking what the assertions assume.

// File: rtl/adw_pkg.sv
package adw_pkg;

  typedef enum logic [1:0] {
    FMT_FULL = 2'b00,
    FMT_MID  = 2'b01,
    FMT_LOW  = 2'b10,
    FMT_ALT  = 2'b11
  } adw_fmt_e;

  localparam int unsigned NUM_LANES = 3;

  // Lane index for a format code; the spare code folds onto the full lane.
  function automatic int unsigned lane_of(input logic [1:0] code);
    case (code)
      FMT_MID: return 1;
      FMT_LOW: return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/adw_lane.sv
module adw_lane #(
  parameter int unsigned MAG_W = 14,
  parameter int unsigned RES   = 14
) (
  input  logic [MAG_W:0] smp_i,
  input  logic           ovl_i,
  output logic [MAG_W+1:0] word_o
);

  localparam int unsigned CUT = MAG_W - RES;

  // Keep the sign and top RES magnitude bits; below them place 1 then 0s.
  function automatic logic [MAG_W:0] shape(input logic [MAG_W:0] s);
    logic [MAG_W:0] r;
    r = s;
    for (int b = 0; b < int'(CUT); b++) begin
      r[b] = (b == int'(CUT) - 1);
    end
    return r;
  endfunction

  assign word_o = {shape(smp_i), ovl_i};

endmodule

// File: rtl/adw_hold.sv
module adw_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_i) word_q <= word_i;
      if (cap_i)      valid_q <= 1'b1;
      else if (clr_i) valid_q <= 1'b0;
    end
  end

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (valid_q && word_q == $past(word_i)));                 // R7
  AST_READ_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cap_i) |=> (!valid_q && $stable(word_q)));             // R8
  AST_CAPTURE_WINS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && cap_i) |=> valid_q);                                    // R9
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(word_q));                                      // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (word_q == '0 && !valid_q));                           // R11

endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int unsigned MAG_W   = 14,
  parameter int unsigned MID_RES = 11,
  parameter int unsigned LOW_RES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [MAG_W:0]    sample_i,
  input  logic              ovr_i,
  input  logic [1:0]        fmt_i,
  input  logic              rd_i,
  output logic [MAG_W+1:0]  word_o,
  output logic              valid_o
);
  import adw_pkg::*;

  localparam int unsigned SMP_W   = MAG_W + 1;
  localparam int unsigned WORD_W  = MAG_W + 2;
  localparam int unsigned MID_CUT = MAG_W - MID_RES;
  localparam int unsigned LOW_CUT = MAG_W - LOW_RES;
  localparam logic [MID_CUT-1:0] MID_TAIL = 1 << (MID_CUT - 1);
  localparam logic [LOW_CUT-1:0] LOW_TAIL = 1 << (LOW_CUT - 1);

  function automatic int unsigned res_of(input int unsigned lane);
    case (lane)
      1:       return MID_RES;
      2:       return LOW_RES;
      default: return MAG_W;
    endcase
  endfunction

  logic [WORD_W-1:0] lane_word [NUM_LANES];
  logic [WORD_W-1:0] fmt_word;
  logic              cap_evt;
  logic              clr_evt;

  for (genvar g = 0; g < int'(NUM_LANES); g++) begin : g_lane
    adw_lane #(.MAG_W(MAG_W), .RES(res_of(g))) u_lane (
      .smp_i  (sample_i),
      .ovl_i  (ovr_i),
      .word_o (lane_word[g])
    );
  end

  assign fmt_word = lane_word[lane_of(fmt_i)];
  assign cap_evt  = done_i;
  assign clr_evt  = rd_i;

  adw_hold #(.WORD_W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap_evt),
    .clr_i   (clr_evt),
    .word_i  (fmt_word),
    .word_q  (word_o),
    .valid_q (valid_o)
  );

  AST_SIGN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> word_o[WORD_W-1] == $past(sample_i[SMP_W-1]));                 // R1
  AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && fmt_i == FMT_FULL) |=> word_o == {$past(sample_i), $past(ovr_i)}); // R2
  AST_MID_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && fmt_i == FMT_MID) |=>
      (word_o[MID_CUT:1] == MID_TAIL &&
       word_o[WORD_W-1:MID_CUT+1] == $past(sample_i[SMP_W-1:MID_CUT])));         // R3
  AST_LOW_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && fmt_i == FMT_LOW) |=>
      (word_o[LOW_CUT:1] == LOW_TAIL &&
       word_o[WORD_W-1:LOW_CUT+1] == $past(sample_i[SMP_W-1:LOW_CUT])));         // R4
  AST_SPARE_AS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && fmt_i == FMT_ALT) |=> word_o == {$past(sample_i), $past(ovr_i)}); // R5
  AST_OVERLOAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> word_o[0] == $past(ovr_i));                                    // R6

endmodule

// File: tb/adc_word_fmt_test.sv
module adc_word_fmt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0;
  logic [14:0] sample_i = '0;
  logic        ovr_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic        rd_i = 1'b0;
  logic [15:0] word_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  adc_word_fmt uut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .sample_i(sample_i),
    .ovr_i(ovr_i), .fmt_i(fmt_i), .rd_i(rd_i), .word_o(word_o), .valid_o(valid_o)
  );

  // {fmt, ovl, sample, expected word}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 1'b0, 15'h3FFE, 16'h7FFC},
    {2'b00, 1'b1, 15'h3FFF, 16'h7FFF},
    {2'b01, 1'b0, 15'h3FF3, 16'h7FE8},
    {2'b01, 1'b1, 15'h3FFF, 16'h7FF9},
    {2'b10, 1'b0, 15'h3F95, 16'h7F40},
    {2'b10, 1'b1, 15'h3FFF, 16'h7FC1},
    {2'b00, 1'b0, 15'h4001, 16'h8002},
    {2'b00, 1'b1, 15'h4000, 16'h8001},
    {2'b01, 1'b0, 15'h400D, 16'h8018},
    {2'b01, 1'b1, 15'h4000, 16'h8009},
    {2'b10, 1'b0, 15'h406A, 16'h80C0},
    {2'b10, 1'b1, 15'h4000, 16'h8041},
    {2'b11, 1'b0, 15'h1234, 16'h2468},
    {2'b00, 1'b1, 15'h0155, 16'h02AB}
  };

  // Truncate to a multiple of the dropped weight, then add half of it.
  function automatic logic [15:0] model(input logic [1:0] f, input logic o, input logic [14:0] s);
    int drop;
    int v;
    drop = (f == 2'b01) ? 3 : (f == 2'b10) ? 6 : 0;
    v = int'(s);
    v = (v / (1 << drop)) * (1 << drop);
    if (drop > 0) v = v + (1 << (drop - 1));
    return {v[14:0], o};
  endfunction

  function automatic string tag_of(input logic [1:0] f);
    case (f)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [1:0] f, input logic o, input logic [14:0] s, input logic rd);
    fmt_i = f; ovr_i = o; sample_i = s; done_i = 1'b1; rd_i = rd;
    @(negedge clk);
    done_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [14:0] lfsr;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset word", 32'(word_o), 32'h0);
    check("R11 reset valid", 32'(valid_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      capture(VEC[i][33:32], VEC[i][31], VEC[i][30:16], 1'b0);
      check({tag_of(VEC[i][33:32]), " R1 R6 example word"}, 32'(word_o), 32'(VEC[i][15:0]));
      check("R7 valid after capture", 32'(valid_o), 32'h1);
    end

    lfsr = 15'h2B3D;
    for (int i = 0; i < 40; i++) begin
      logic [1:0] f;
      logic o;
      f = 2'(i % 4);
      o = lfsr[0] ^ lfsr[7];
      capture(f, o, lfsr, 1'b0);
      check({tag_of(f), " R1 R6 model word"}, 32'(word_o), 32'(model(f, o, lfsr)));
      lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
    end

    // R10: inputs move without done; word unchanged
    held = word_o;
    sample_i = ~sample_i; ovr_i = ~ovr_i; fmt_i = 2'b10;
    repeat (3) @(negedge clk);
    check("R10 word held without done", 32'(word_o), 32'(held));

    // R8: read drops valid, word kept
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R8 valid cleared", 32'(valid_o), 32'h0);
    check("R8 word kept", 32'(word_o), 32'(held));

    // R9: done and read on the same edge
    capture(2'b01, 1'b0, 15'h0A5F, 1'b1);
    check("R9 valid kept", 32'(valid_o), 32'h1);
    check("R9 new word", 32'(word_o), 32'h14B8);

    // R7: overwrite before read
    capture(2'b10, 1'b1, 15'h7FC0, 1'b0);
    check("R7 overwrite word", 32'(word_o), 32'hFFC1);

    // R11: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid reset word", 32'(word_o), 32'h0);
    check("R11 mid reset valid", 32'(valid_o), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule